// File: doc/BRIEF.md
# Banked Program Counter with Interrupt Sequencer

This block produces the next instruction address for a 13-bit program space. The space is split into two 4K banks. A 12-bit program counter selects the word inside a bank. The bank bit is not part of the counter: it is a latch that the output-port write path loads, and no sequencing operation ever changes it. Each cycle in which the core marks an instruction boundary (`step`), the block applies one operation. The operation is one of: advance by one, advance by two, absolute jump, call, conditional branch, plain return, or interrupt return.

A single stack entry holds one return address and one carry bit. A call stores the address two words past the current one, and its carry slot is cleared. An interrupt stores the address of the instruction it pre-empts, together with the live carry flag. That instruction is re-fetched after the interrupt return, and the saved carry is handed back to the core one cycle later.

Timer overflow and external wake events are latched as pending requests. They are accepted only at a boundary, and only while interrupts are enabled and the stack is free. The stack is free when neither a subroutine nor a service routine is active. The timer request wins when both are pending.

Top module: `banked_pc_seq`

## Requirements
- R1: While `rst_n` is low, and after it rises, the state is as follows: `pc` is 000H, `bank` is 1 (so `fetch_addr` is 1000H), interrupts are disabled, both requests are clear, and `in_sub` and `in_isr` are 0.
- R2: On a boundary with `op`=1, `pc` advances by 1. With `op`=2 it advances by 2. Both wrap modulo 4096 and leave `bank` unchanged.
- R3: On a boundary with `op`=3 (jump) or `op`=4 (call), all 12 bits of `pc` are loaded from `target`.
- R4: On a boundary with `op`=5 (branch), a taken branch (`br_taken`=1) loads `pc[10:0]` from `target[10:0]` and keeps `pc[11]`. A branch that is not taken advances `pc` by 2.
- R5: A call stores `pc`+2 with a cleared carry slot and sets `in_sub`. A plain return (`op`=6) reloads `pc` from the stack, clears `in_sub` and does not pulse `carry_ld`.
- R6: An interrupt is taken at a boundary only when interrupts are enabled, `in_sub` and `in_isr` are both 0, and a request is pending. The operation on `op` is then discarded. `pc` becomes 004H for the timer or 008H for the external event, and `bank` is kept. The stack receives the current `pc` and `carry_in`, and `in_isr` is set. The take is flagged on `take_tmr`/`take_ext` in that same cycle.
- R7: When both requests are pending at an accepted boundary, the timer interrupt is taken, and the external request stays pending.
- R8: An interrupt return (`op`=7) reloads `pc` from the stack and clears `in_isr`. In the next cycle `carry_ld` is 1 and `carry_val` is the saved carry.
- R9: A pulse on `tmr_evt`/`ext_evt` sets its request. The request holds until its interrupt is taken, which clears it. If an event arrives in the same cycle as the take, the request stays set.
- R10: `ei_cmd` enables interrupts from the next cycle. `di_cmd` disables them, and wins when both are high.
- R11: `bank` loads `bank_in` in any cycle with `bank_wr`=1, and changes at no other time.
- R12: With `step`=0, `pc`, the stack and the two busy flags hold, and no interrupt is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| step | input | 1 | Instruction boundary; apply `op` or take an interrupt |
| op | input | 3 | 0 hold, 1 +1, 2 +2, 3 jump, 4 call, 5 branch, 6 return, 7 interrupt return |
| br_taken | input | 1 | Branch condition result for `op`=5 |
| target | input | 12 | Jump/call/branch destination |
| carry_in | input | 1 | Live carry flag, saved on interrupt entry |
| bank_wr | input | 1 | Output-port write strobe for the bank bit |
| bank_in | input | 1 | New bank bit value |
| ei_cmd | input | 1 | Enable interrupts |
| di_cmd | input | 1 | Disable interrupts |
| tmr_evt | input | 1 | Timer overflow pulse |
| ext_evt | input | 1 | External wake event pulse |
| pc | output | 12 | Program counter |
| bank | output | 1 | Bank bit |
| fetch_addr | output | 13 | `{bank, pc}` |
| int_en | output | 1 | Interrupts enabled |
| in_sub | output | 1 | Subroutine active |
| in_isr | output | 1 | Service routine active |
| tmr_pend | output | 1 | Timer request pending |
| ext_pend | output | 1 | External request pending |
| take_tmr | output | 1 | Timer interrupt accepted this cycle |
| take_ext | output | 1 | External interrupt accepted this cycle |
| carry_ld | output | 1 | Restore carry this cycle |
| carry_val | output | 1 | Carry value to restore |

## Verification
A stale busy flag would show as a missing or premature `take_tmr`/`take_ext`, at the first boundary where a request is pending. A wrong enable bit shows the same way, so the reference model compares those strobes in every cycle. A corrupt stack entry stays hidden until the next return. It then appears as a wrong `pc` in the cycle after that return, or, for the carry slot, as a wrong `carry_val` one cycle later. Runs of calls and interrupts with returns are therefore interleaved densely, so that each stored value is read back within a few cycles.

// File: rtl/banked_pc_seq.sv
module banked_pc_seq #(
  parameter int PCW = 12,
  parameter int BRW = 11,
  parameter logic [PCW-1:0] TMR_VEC = 12'h004,
  parameter logic [PCW-1:0] EXT_VEC = 12'h008
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           step,
  input  logic [2:0]     op,
  input  logic           br_taken,
  input  logic [PCW-1:0] target,
  input  logic           carry_in,
  input  logic           bank_wr,
  input  logic           bank_in,
  input  logic           ei_cmd,
  input  logic           di_cmd,
  input  logic           tmr_evt,
  input  logic           ext_evt,
  output logic [PCW-1:0] pc,
  output logic           bank,
  output logic [PCW:0]   fetch_addr,
  output logic           int_en,
  output logic           in_sub,
  output logic           in_isr,
  output logic           tmr_pend,
  output logic           ext_pend,
  output logic           take_tmr,
  output logic           take_ext,
  output logic           carry_ld,
  output logic           carry_val
);
  localparam logic [2:0] OP_INC1 = 3'd1, OP_INC2 = 3'd2, OP_JMP = 3'd3, OP_CALL = 3'd4,
                         OP_BR = 3'd5, OP_RET = 3'd6, OP_RETI = 3'd7;

  logic [PCW-1:0] stk_pc;
  logic           stk_c;
  logic           accept;
  logic [PCW-1:0] pc_p1, pc_p2;

  assign accept     = step & int_en & ~in_sub & ~in_isr;
  assign take_tmr   = accept & tmr_pend;
  assign take_ext   = accept & ext_pend & ~tmr_pend;
  assign fetch_addr = {bank, pc};
  assign pc_p1      = pc + PCW'(1);
  assign pc_p2      = pc + PCW'(2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0; bank <= 1'b1; int_en <= 1'b0;
      in_sub <= 1'b0; in_isr <= 1'b0;
      tmr_pend <= 1'b0; ext_pend <= 1'b0;
      stk_pc <= '0; stk_c <= 1'b0;
      carry_ld <= 1'b0; carry_val <= 1'b0;
    end else begin
      carry_ld <= 1'b0;
      if (bank_wr) bank <= bank_in;
      if (di_cmd) int_en <= 1'b0;
      else if (ei_cmd) int_en <= 1'b1;
      tmr_pend <= tmr_evt | (tmr_pend & ~take_tmr);
      ext_pend <= ext_evt | (ext_pend & ~take_ext);
      if (take_tmr || take_ext) begin
        pc     <= take_tmr ? TMR_VEC : EXT_VEC;
        stk_pc <= pc;
        stk_c  <= carry_in;
        in_isr <= 1'b1;
      end else if (step) begin
        unique case (op)
          OP_INC1: pc <= pc_p1;
          OP_INC2: pc <= pc_p2;
          OP_JMP:  pc <= target;
          OP_CALL: begin
            stk_pc <= pc_p2; stk_c <= 1'b0; in_sub <= 1'b1; pc <= target;
          end
          OP_BR:   pc <= br_taken ? {pc[PCW-1:BRW], target[BRW-1:0]} : pc_p2;
          OP_RET:  begin pc <= stk_pc; in_sub <= 1'b0; end
          OP_RETI: begin
            pc <= stk_pc; in_isr <= 1'b0; carry_ld <= 1'b1; carry_val <= stk_c;
          end
          default: ;
        endcase
      end
    end
  end

  p_prio_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({take_tmr, take_ext}));
  p_tvec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take_tmr |=> (pc == TMR_VEC) && in_isr);
  p_evec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take_ext |=> (pc == EXT_VEC) && in_isr);
  p_bank_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_wr |=> bank == $past(bank));
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> (pc == $past(pc)) && (in_sub == $past(in_sub)) && (in_isr == $past(in_isr)));
  p_br_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && op == OP_BR && br_taken && !take_tmr && !take_ext) |=> pc[PCW-1] == $past(pc[PCW-1]));
  p_cld_r8: assert property (@(posedge clk) disable iff (!rst_n)
    carry_ld |-> !in_isr);
endmodule

// File: tb/test_banked_pc_seq.sv
`timescale 1ns/1ps
module test_banked_pc_seq;
  logic clk = 0, rst_n = 0;
  logic step = 0, br_taken = 0, carry_in = 0, bank_wr = 0, bank_in = 0;
  logic ei_cmd = 0, di_cmd = 0, tmr_evt = 0, ext_evt = 0;
  logic [2:0] op = 0;
  logic [11:0] target = 0;
  logic [11:0] pc; logic bank; logic [12:0] fetch_addr;
  logic int_en, in_sub, in_isr, tmr_pend, ext_pend, take_tmr, take_ext, carry_ld, carry_val;
  int checks = 0, failures = 0;
  string req = "R1";
  bit done = 0;

  int m_pc, m_bank, m_en, m_sub, m_isr, m_tp, m_ep, m_spc, m_sc, m_cld, m_cv;

  always #2 clk = ~clk;

  banked_pc_seq i_banked_pc_seq (.*);

  task automatic chk(string r, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  function automatic int m_acc();
    return (step && m_en && !m_sub && !m_isr) ? 1 : 0;
  endfunction

  task automatic model_reset();
    m_pc = 0; m_bank = 1; m_en = 0; m_sub = 0; m_isr = 0; m_tp = 0; m_ep = 0;
    m_spc = 0; m_sc = 0; m_cld = 0; m_cv = 0;
  endtask

  task automatic model_edge();
    int tt, te;
    tt = m_acc() && m_tp;
    te = m_acc() && m_ep && !m_tp;
    m_cld = 0;
    if (bank_wr) m_bank = bank_in;
    if (di_cmd) m_en = 0; else if (ei_cmd) m_en = 1;
    if (tt || te) begin
      m_spc = m_pc; m_sc = carry_in; m_isr = 1;
      m_pc = tt ? 4 : 8;
    end else if (step) begin
      case (op)
        1: m_pc = (m_pc + 1) % 4096;
        2: m_pc = (m_pc + 2) % 4096;
        3: m_pc = target;
        4: begin m_spc = (m_pc + 2) % 4096; m_sc = 0; m_sub = 1; m_pc = target; end
        5: if (br_taken) m_pc = (m_pc / 2048) * 2048 + (target % 2048);
           else m_pc = (m_pc + 2) % 4096;
        6: begin m_pc = m_spc; m_sub = 0; end
        7: begin m_pc = m_spc; m_isr = 0; m_cld = 1; m_cv = m_sc; end
        default: ;
      endcase
    end
    if (tt) m_tp = 0;
    if (te) m_ep = 0;
    if (tmr_evt) m_tp = 1;
    if (ext_evt) m_ep = 1;
  endtask

  task automatic cmp_state();
    chk(req, "pc", pc, m_pc);
    chk(req, "bank", bank, m_bank);
    chk(req, "fetch_addr", fetch_addr, m_bank * 4096 + m_pc);
    chk(req, "int_en", int_en, m_en);
    chk(req, "in_sub", in_sub, m_sub);
    chk(req, "in_isr", in_isr, m_isr);
    chk(req, "tmr_pend", tmr_pend, m_tp);
    chk(req, "ext_pend", ext_pend, m_ep);
    chk(req, "carry_ld", carry_ld, m_cld);
    if (m_cld) chk(req, "carry_val", carry_val, m_cv);
  endtask

  task automatic cyc();
    #1;
    chk(req, "take_tmr", take_tmr, m_acc() && m_tp);
    chk(req, "take_ext", take_ext, m_acc() && m_ep && !m_tp);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    cmp_state();
    step = 0; op = 0; br_taken = 0; bank_wr = 0; ei_cmd = 0; di_cmd = 0;
    tmr_evt = 0; ext_evt = 0;
  endtask

  task automatic do_op(int o, int t);
    step = 1; op = 3'(o); target = 12'(t); cyc();
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    req = "R1";
    cmp_state();
    chk("R1", "fetch_addr literal", fetch_addr, 13'h1000);
    rst_n = 1;
    cyc();
    chk("R1", "pc after release", pc, 0);
    req = "R2"; do_op(1, 0); do_op(2, 0);
    chk("R2", "pc +1+2", pc, 3);
    req = "R3"; do_op(3, 12'hABC);
    chk("R3", "jump", pc, 12'hABC);
    req = "R4"; br_taken = 1; do_op(5, 12'h123);
    chk("R4", "taken keeps bit11", pc, 12'h923);
    do_op(5, 12'h456);
    chk("R4", "not taken +2", pc, 12'h925);
    req = "R5"; do_op(4, 12'h200);
    chk("R5", "call target", pc, 12'h200);
    chk("R5", "in_sub set", in_sub, 1);
    do_op(6, 0);
    chk("R5", "return addr", pc, 12'h927);
    chk("R5", "no carry_ld", carry_ld, 0);
    req = "R10"; ei_cmd = 1; di_cmd = 1; cyc();
    chk("R10", "di wins", int_en, 0);
    ei_cmd = 1; cyc();
    chk("R10", "ei", int_en, 1);
    req = "R6"; do_op(4, 12'h300); tmr_evt = 1; cyc();
    chk("R9", "timer pending", tmr_pend, 1);
    do_op(1, 0);
    chk("R6", "deferred in sub", pc, 12'h301);
    do_op(6, 0);
    chk("R6", "return first", pc, 12'h929);
    carry_in = 1; do_op(3, 12'h777);
    chk("R6", "timer vector", pc, 12'h004);
    chk("R9", "timer cleared", tmr_pend, 0);
    req = "R8"; carry_in = 0; do_op(7, 0);
    chk("R8", "reti pc", pc, 12'h929);
    chk("R8", "carry_ld", carry_ld, 1);
    chk("R8", "carry_val", carry_val, 1);
    req = "R7"; di_cmd = 1; tmr_evt = 1; ext_evt = 1; cyc();
    ei_cmd = 1; cyc();
    do_op(1, 0);
    chk("R7", "timer first", pc, 12'h004);
    chk("R7", "ext still pending", ext_pend, 1);
    do_op(7, 0);
    do_op(1, 0);
    chk("R7", "ext vector", pc, 12'h008);
    do_op(7, 0);
    req = "R11"; bank_wr = 1; bank_in = 0; cyc();
    chk("R11", "bank written", fetch_addr, {1'b0, 12'h929});
    req = "R12"; ext_evt = 1; cyc();
    repeat (4) cyc();
    chk("R12", "pc held", pc, 12'h929);
    chk("R12", "no take without step", ext_pend, 1);
    req = "R9"; step = 1; op = 1; ext_evt = 1; cyc();
    chk("R9", "event during take stays", ext_pend, 1);
    chk("R6", "bank kept", bank, 0);
    do_op(7, 0);
    req = "R2";
    for (int i = 0; i < 3000; i++) begin
      step = ($urandom % 10) < 8; op = 3'($urandom); br_taken = 1'($urandom);
      target = 12'($urandom); carry_in = 1'($urandom);
      bank_wr = ($urandom % 20) == 0; bank_in = 1'($urandom);
      ei_cmd = ($urandom % 8) == 0; di_cmd = ($urandom % 30) == 0;
      tmr_evt = ($urandom % 15) == 0; ext_evt = ($urandom % 15) == 0;
      cyc();
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule